// File: doc/BRIEF.md
# Multichannel I/Q Parallel Output Sequencer

This block collects complex samples from several downconverter channels and places them one word per clock onto a single shared parallel bus. Each channel raises a one-cycle strobe when a new in-phase/quadrature pair is available. The block keeps that pair until its in-phase word has been sent. The words go out as I then Q for each channel. In framed (synchronous) operation, every channel is sent in one burst. In unframed (asynchronous) operation, each ready channel is sent as its own pair.

Two flag outputs travel with the bus. A format select sets what they mean. In the split format, one flag marks in-phase words and the other marks quadrature words. In the marker format, the first flag marks every valid word and the second flag marks frame starts. The frame-start marker covers the word that opens on channel 0's in-phase sample, and also the closing word directly before it. Each flag has its own polarity inversion. A downstream capture device can therefore lock on to the channel order using only the flags.

Top module: `iq_word_sequencer`

## Requirements
- R1: In framed mode a frame is 2*NCH words on consecutive clocks, in the order ch0-I, ch0-Q, ch1-I, ch1-Q, up to the last channel's Q.
- R2: With format select 0 or 1, flag_a (before inversion) is high only for an I word and flag_b only for a Q word.
- R3: With format select 2 or 3, flag_a (before inversion) is high for every valid word, I or Q.
- R4: With format select 2 or 3, flag_b (before inversion) is high on every ch0-I word. It is also high on the last word of a frame or pair when the very next word is a ch0-I word. Otherwise it is low.
- R5: In framed mode a frame starts only when every channel holds an unsent sample. Until then nothing is sent.
- R6: In unframed mode, each channel holding a sample sends its I then Q on consecutive clocks. When several channels are waiting, the lowest channel index goes first.
- R7: inv_a inverts flag_a and inv_b inverts flag_b, including while idle.
- R8: When no word is sent, both flags are at their inactive level and pbus keeps its previous value.
- R9: sync_en, flag_mode, inv_a and inv_b are sampled only when a frame or pair starts. A change made mid-frame has no effect until the next start.
- R10: A strobe stores that channel's I and Q inputs and overwrites any older unsent sample. The Q word sent is the one stored together with the I word already sent. A strobe in the same cycle that a channel's I word is taken counts as a new sample.
- R11: From idle, the first word appears on the outputs after the second rising edge following the edge that captures the enabling strobe. A frame or pair that can start when the previous one closes follows with no gap.
- R12: A synchronous reset returns the block to idle with no samples held, pbus = 0, and flag_a = inv_a, flag_b = inv_b, taken from the inputs during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one output word per cycle |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | NCH | Per-channel new-sample strobe |
| smp_i | input | NCH*W | In-phase inputs, channel c at bits [c*W +: W] |
| smp_q | input | NCH*W | Quadrature inputs, same packing |
| sync_en | input | 1 | 1 = framed mode, 0 = unframed pairs |
| flag_mode | input | 2 | 0/1 = I/Q flags, 2/3 = valid + frame marker |
| inv_a | input | 1 | Invert flag_a |
| inv_b | input | 1 | Invert flag_b |
| pbus | output | W | Shared parallel output word |
| flag_a | output | 1 | I-valid or word-valid flag |
| flag_b | output | 1 | Q-valid flag or frame marker |

## Verification
A wrong channel index or phase bit shows on the next output cycle: the bus carries a word from the wrong hold register, or the flags swap I and Q. A lost or stale pending bit shows up as a frame that starts a cycle early, late, or never. That error appears within two clocks of the strobe that should have completed the set. A wrong lookahead on the closing word shows as a missing or extra marker pulse on the word just before a ch0-I word. The reference model compares bus and flags on every cycle, so each of these errors is reported in the cycle where it first appears.

// File: rtl/iqseq_pkg.sv
package iqseq_pkg;
    typedef struct packed {
        logic       sync;
        logic [1:0] fmode;
        logic       inv_a;
        logic       inv_b;
    } ctrl_t;
endpackage

// File: rtl/iqseq_hold.sv
module iqseq_hold #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stb,
    input  logic [W-1:0] din_i,
    input  logic [W-1:0] din_q,
    input  logic         take,
    output logic         pend,
    output logic [W-1:0] dout_i,
    output logic [W-1:0] dout_q
);
    typedef struct packed {
        logic         pend;
        logic [W-1:0] di;
        logic [W-1:0] dq;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (take) h_d.pend = 1'b0;
        // a fresh strobe wins over a take in the same cycle
        if (stb) begin
            h_d.pend = 1'b1;
            h_d.di   = din_i;
            h_d.dq   = din_q;
        end
        if (rst) h_d = '0;
    end

    always_ff @(posedge clk) h_q <= h_d;

    assign pend   = h_q.pend;
    assign dout_i = h_q.di;
    assign dout_q = h_q.dq;
endmodule

// File: rtl/iqseq_pick.sv
module iqseq_pick #(
    parameter int unsigned NCH = 4,
    localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] pend,
    input  logic           sync_sel,
    output logic           ok,
    output logic [CW-1:0]  ch
);
    always_comb begin
        ch = '0;
        if (sync_sel) begin
            ok = &pend;
        end else begin
            ok = |pend;
            for (int k = NCH - 1; k >= 0; k--) begin
                if (pend[k]) ch = CW'(k);
            end
        end
    end
endmodule

// File: rtl/iqseq_flags.sv
module iqseq_flags (
    input  logic       valid,
    input  logic       is_q,
    input  logic       marker,
    input  logic [1:0] fmode,
    input  logic       inv_a,
    input  logic       inv_b,
    output logic       fa,
    output logic       fb
);
    logic raw_a, raw_b;

    always_comb begin
        if (fmode[1]) begin
            raw_a = valid;
            raw_b = marker;
        end else begin
            raw_a = valid & ~is_q;
            raw_b = valid & is_q;
        end
        fa = raw_a ^ inv_a;
        fb = raw_b ^ inv_b;
    end
endmodule

// File: rtl/iq_word_sequencer.sv
module iq_word_sequencer
    import iqseq_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned W   = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   smp_stb,
    input  logic [NCH*W-1:0] smp_i,
    input  logic [NCH*W-1:0] smp_q,
    input  logic             sync_en,
    input  logic [1:0]       flag_mode,
    input  logic             inv_a,
    input  logic             inv_b,
    output logic [W-1:0]     pbus,
    output logic             flag_a,
    output logic             flag_b
);
    localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        logic          s1_vld;
        logic [CW-1:0] s1_ch;
        logic          s1_ph;
        logic          s1_last;
        logic [W-1:0]  s1_dat;
        logic [W-1:0]  qst;
        ctrl_t         ctl;
        logic [W-1:0]  bus;
        logic          fa;
        logic          fb;
    } st_t;

    st_t r_d, r_q;

    logic [NCH-1:0] pend, take;
    logic [W-1:0]   hold_i [NCH];
    logic [W-1:0]   hold_q [NCH];
    logic           start_ok;
    logic [CW-1:0]  pick_ch;
    logic           cand_vld, cand_ph, cand_last, marker, fa_w, fb_w;
    logic [CW-1:0]  cand_ch;
    ctrl_t          nctl;

    for (genvar c = 0; c < NCH; c++) begin : g_hold
        iqseq_hold #(.W(W)) u_hold (
            .clk   (clk),
            .rst   (rst),
            .stb   (smp_stb[c]),
            .din_i (smp_i[c*W +: W]),
            .din_q (smp_q[c*W +: W]),
            .take  (take[c]),
            .pend  (pend[c]),
            .dout_i(hold_i[c]),
            .dout_q(hold_q[c])
        );
    end

    iqseq_pick #(.NCH(NCH)) u_pick (
        .pend    (pend),
        .sync_sel(sync_en),
        .ok      (start_ok),
        .ch      (pick_ch)
    );

    iqseq_flags u_flags (
        .valid (r_q.s1_vld),
        .is_q  (r_q.s1_ph),
        .marker(marker),
        .fmode (r_q.ctl.fmode),
        .inv_a (r_q.ctl.inv_a),
        .inv_b (r_q.ctl.inv_b),
        .fa    (fa_w),
        .fb    (fb_w)
    );

    always_comb begin
        r_d      = r_q;
        cand_vld = 1'b0;
        cand_ch  = '0;
        cand_ph  = 1'b0;
        nctl     = r_q.ctl;
        take     = '0;

        // choose the word entering stage 1
        if (r_q.s1_vld && !r_q.s1_last) begin
            cand_vld = 1'b1;
            if (!r_q.s1_ph) begin
                cand_ch = r_q.s1_ch;
                cand_ph = 1'b1;
            end else begin
                cand_ch = r_q.s1_ch + 1'b1;
            end
        end else if (start_ok) begin
            cand_vld = 1'b1;
            cand_ch  = pick_ch;
            nctl     = '{sync: sync_en, fmode: flag_mode, inv_a: inv_a, inv_b: inv_b};
        end

        cand_last = cand_vld && cand_ph && (!nctl.sync || cand_ch == CW'(NCH - 1));

        marker = r_q.s1_vld &&
                 ((r_q.s1_ch == '0 && !r_q.s1_ph) ||
                  (r_q.s1_last && cand_vld && cand_ch == '0 && !cand_ph));

        r_d.s1_vld  = cand_vld;
        r_d.s1_ch   = cand_ch;
        r_d.s1_ph   = cand_ph;
        r_d.s1_last = cand_last;
        r_d.ctl     = nctl;
        if (cand_vld) begin
            if (cand_ph) begin
                r_d.s1_dat = r_q.qst;
            end else begin
                r_d.s1_dat     = hold_i[cand_ch];
                r_d.qst        = hold_q[cand_ch];
                take[cand_ch]  = 1'b1;
            end
        end

        // output stage
        if (r_q.s1_vld) r_d.bus = r_q.s1_dat;
        r_d.fa = fa_w;
        r_d.fb = fb_w;

        if (rst) begin
            r_d     = '0;
            r_d.ctl = '{sync: sync_en, fmode: flag_mode, inv_a: inv_a, inv_b: inv_b};
            r_d.fa  = inv_a;
            r_d.fb  = inv_b;
        end
    end

    always_ff @(posedge clk) r_q <= r_d;

    assign pbus   = r_q.bus;
    assign flag_a = r_q.fa;
    assign flag_b = r_q.fb;
endmodule

// File: rtl/iqseq_chk.sv
module iqseq_chk #(
    parameter int unsigned W = 24
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] pbus,
    input logic         flag_a,
    input logic         flag_b,
    input logic [1:0]   l_fm,
    input logic         l_ia,
    input logic         l_ib
);
    // controls that were in force when the current outputs were registered
    logic [1:0] fm_p;
    logic       ia_p, ib_p;
    logic       ra, rb;

    always_ff @(posedge clk) begin
        fm_p <= l_fm;
        ia_p <= l_ia;
        ib_p <= l_ib;
    end

    assign ra = flag_a ^ ia_p;
    assign rb = flag_b ^ ib_p;

    // R2: I and Q flags never together
    p_iq_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
        (!fm_p[1]) |-> !(ra && rb));

    // R2: every I word is followed by its Q word
    p_q_after_i_r2: assert property (@(posedge clk) disable iff (rst)
        (!fm_p[1] && ra) |=> (rb && !ra));

    // R4: the marker only accompanies a valid word
    p_marker_on_word_r4: assert property (@(posedge clk) disable iff (rst)
        (fm_p[1] && rb) |-> ra);

    // R8: bus holds when nothing is sent (marker format)
    p_hold_marker_r8: assert property (@(posedge clk) disable iff (rst)
        (fm_p[1] && !ra) |-> $stable(pbus));

    // R8: bus holds when nothing is sent (split format)
    p_hold_split_r8: assert property (@(posedge clk) disable iff (rst)
        (!fm_p[1] && !ra && !rb) |-> $stable(pbus));
endmodule

bind iq_word_sequencer iqseq_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .pbus  (pbus),
    .flag_a(flag_a),
    .flag_b(flag_b),
    .l_fm  (r_q.ctl.fmode),
    .l_ia  (r_q.ctl.inv_a),
    .l_ib  (r_q.ctl.inv_b)
);

// File: tb/iq_word_sequencer_test.sv
module iq_word_sequencer_test;
    localparam int NCH = 4;
    localparam int W   = 24;
    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst;
    logic [NCH-1:0]   smp_stb;
    logic [NCH*W-1:0] smp_i, smp_q;
    logic             sync_en;
    logic [1:0]       flag_mode;
    logic             inv_a, inv_b;
    logic [W-1:0]     pbus;
    logic             flag_a, flag_b;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    string phase = "R12 reset";

    iq_word_sequencer #(.NCH(NCH), .W(W)) uut (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_i(smp_i), .smp_q(smp_q),
        .sync_en(sync_en), .flag_mode(flag_mode), .inv_a(inv_a), .inv_b(inv_b),
        .pbus(pbus), .flag_a(flag_a), .flag_b(flag_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- reference model ----------------
    bit           m_pend [NCH];
    logic [W-1:0] m_hi [NCH];
    logic [W-1:0] m_hq [NCH];
    int           tq[$];
    bit           m_s1v, m_s1last;
    int           m_s1tag;
    logic [W-1:0] m_s1d, m_stq;
    logic [1:0]   m_fm;
    bit           m_ia, m_ib, m_sync;
    logic [W-1:0] e_bus;
    bit           e_fa, e_fb;

    task automatic model_step();
        bit cv, clast, started, ra, rb, all;
        int ctag;
        logic [W-1:0] cd;
        cv = 0; clast = 0; started = 0; ctag = 0; cd = '0;
        if (rst) begin
            for (int c = 0; c < NCH; c++) m_pend[c] = 0;
            tq.delete();
            m_s1v = 0; m_s1last = 0; m_s1tag = 0; m_s1d = '0; m_stq = '0;
            e_bus = '0;
            m_fm = flag_mode; m_ia = inv_a; m_ib = inv_b; m_sync = sync_en;
            e_fa = inv_a; e_fb = inv_b;
            return;
        end
        if (tq.size() == 0) begin
            if (sync_en) begin
                all = 1;
                for (int c = 0; c < NCH; c++) if (!m_pend[c]) all = 0;
                if (all) for (int t = 0; t < 2*NCH; t++) tq.push_back(t);
            end else begin
                for (int c = 0; c < NCH; c++) begin
                    if (m_pend[c]) begin
                        tq.push_back(2*c); tq.push_back(2*c+1);
                        break;
                    end
                end
            end
            started = (tq.size() > 0);
        end
        if (tq.size() > 0) begin
            cv = 1; ctag = tq.pop_front(); clast = (tq.size() == 0);
        end
        // outputs for the word held in stage 1
        if (m_s1v) e_bus = m_s1d;
        if (m_fm[1]) begin
            ra = m_s1v;
            rb = m_s1v && (m_s1tag == 0 || (m_s1last && cv && ctag == 0));
        end else begin
            ra = m_s1v && (m_s1tag % 2 == 0);
            rb = m_s1v && (m_s1tag % 2 == 1);
        end
        e_fa = ra ^ m_ia;
        e_fb = rb ^ m_ib;
        if (cv) begin
            if (ctag % 2 == 0) begin
                cd = m_hi[ctag/2];
                m_stq = m_hq[ctag/2];
                m_pend[ctag/2] = 0;
            end else begin
                cd = m_stq;
            end
        end
        m_s1v = cv; m_s1tag = ctag; m_s1last = clast; m_s1d = cd;
        if (started) begin
            m_fm = flag_mode; m_ia = inv_a; m_ib = inv_b; m_sync = sync_en;
        end
        for (int c = 0; c < NCH; c++) begin
            if (smp_stb[c]) begin
                m_pend[c] = 1;
                m_hi[c] = smp_i[c*W +: W];
                m_hq[c] = smp_q[c*W +: W];
            end
        end
    endtask

    task automatic compare();
        n_tests++;
        if (pbus !== e_bus || flag_a !== e_fa || flag_b !== e_fb) begin
            n_fail++;
            $display("FAIL [%s] cycle %0d: bus %h/%b/%b expected %h/%b/%b",
                     phase, cyc, pbus, flag_a, flag_b, e_bus, e_fa, e_fb);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        smp_stb = '0;
        for (int c = 0; c < NCH; c++) begin
            smp_i[c*W +: W] = W'($urandom);
            smp_q[c*W +: W] = W'($urandom);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; smp_stb = '0; smp_i = '0; smp_q = '0;
        sync_en = 0; flag_mode = 0; inv_a = 1; inv_b = 0;
        @(negedge clk);
        idle(3);
        // R12: reset level of flags follows the invert inputs
        n_tests++;
        if (pbus !== '0 || flag_a !== 1'b1 || flag_b !== 1'b0) begin
            n_fail++;
            $display("FAIL R12 reset outputs %h/%b/%b expected 0/1/0", pbus, flag_a, flag_b);
        end
        rst = 0; inv_a = 0;
        idle(2);

        phase = "R6 R11 R2 R8 single pair";
        smp_stb = 4'b0010; tick(); idle(6);

        phase = "R6 priority";
        smp_stb = 4'b1101; tick(); idle(10);

        phase = "R10 replace and same-cycle strobe";
        smp_stb = 4'b0100; tick(); smp_stb = 4'b0100; tick();
        smp_stb = 4'b0100; tick(); idle(8);

        phase = "R5 R1 R11 framed split";
        sync_en = 1;
        smp_stb = 4'b0111; tick(); idle(4);
        smp_stb = 4'b1000; tick(); idle(3);
        for (int f = 0; f < 5; f++) begin
            smp_stb = 4'b1111; tick(); idle(7);
        end
        idle(6);

        phase = "R4 R3 R1 framed marker";
        flag_mode = 2;
        for (int f = 0; f < 4; f++) begin
            smp_stb = 4'b1111; tick(); idle(7);
        end
        idle(6);

        phase = "R9 mid-frame control change";
        smp_stb = 4'b1111; tick(); tick();
        flag_mode = 0; inv_a = 1; inv_b = 1; idle(10);
        smp_stb = 4'b1111; tick(); idle(12);

        phase = "R7 R4 R6 unframed marker inverted";
        sync_en = 0; flag_mode = 3;
        for (int k = 0; k < 200; k++) begin
            smp_stb = NCH'($urandom);
            tick();
        end
        idle(20);

        phase = "R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 mixed";
        for (int k = 0; k < 3000; k++) begin
            if ($urandom % 40 == 0) begin
                sync_en = 1'($urandom); flag_mode = 2'($urandom);
                inv_a = 1'($urandom); inv_b = 1'($urandom);
            end
            smp_stb = ($urandom % 3 == 0) ? NCH'($urandom) : '0;
            tick();
        end
        idle(20);

        phase = "R12 reset mid-traffic";
        sync_en = 0; smp_stb = 4'b1111; tick(); tick();
        rst = 1; inv_a = 0; inv_b = 1; idle(3);
        rst = 0; idle(6);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule